// File: doc/BRIEF.md
# Cascadable Content-Addressable Memory Slice

This block is one slice of a content-addressable memory: sixteen 16-bit entries, each with its own validity bit, searched in parallel against a comparand register under a mask register. Identical slices stack vertically on one shared bidirectional 16-bit bus. Each slice holds a page number that forms the upper bits of every address it reports, so a stack reports system-wide match addresses with no outside priority logic.

A host drives the bus with an enable strobe and two cycle-type inputs: command or data, and write or read. Command words choose where data writes land and where data reads come from. These choices persist until the next select command. Command words also run forced compares, clear validity bits and write the comparand into the next free entry. Match and full indications ripple from slice to slice through active-low chain pins. Only the slice holding the system's best match, or the system's first free entry, answers the reads that concern it.

Top module: `cam_slice`

## Requirements
- R1: A bus cycle takes place on a rising clock edge with `en` high. `is_cmd` high marks a command, `is_wr` high marks a write. The command opcode sits in dq[15:12]: 1 sets the write target, 2 sets the read source (dq[1:0]: 0 comparand, 1 mask, 2 entry at the address register), 3 forces a compare, 4 moves to the next free entry, 5 loads the address register from dq[3:0], 6 clears the validity bit of entry dq[3:0], 7 picks the command-read word (dq[1:0]: 0 status address, 1 status flags, 2 next-free address), 8 sends the next data write to device select, 9 sends it to the page register. The write target and read source persist until changed.
- R2: A data write to the comparand or the mask, or a forced compare, runs a compare that uses the newly written value. The status register and the match pins show the result from the following clock cycle. No other operation changes the status.
- R3: An entry matches when its validity bit is set and it equals the comparand in every bit position whose mask bit is 0. A mask bit of 1 makes that position a don't-care. An invalid entry never matches.
- R4: When several entries match, the lowest local address is reported, and the multiple-match flag is raised only when two or more entries match.
- R5: The status address word is {page[11:0], local address[3:0]}. The status flags word carries full in bit 2, multiple match in bit 1 and match in bit 0, all active-high, with zeros above. The `match_n` and `multi_n` pins show the status flags active-low.
- R6: A slice is selected when device select equals FFFFh or equals its zero-extended page. Every enabled slice accepts opcode 8 and the data write that follows it, whether it is selected or not. Opcode 9 and its data write act only on a selected slice.
- R7: An unselected slice ignores every command and data cycle except device-select loading, and never drives the bus.
- R8: A slice whose status shows no match does not drive data reads or status reads. It may still answer a next-free read.
- R9: A status read, of either the address word or the flags word, is driven only by a slice with a match whose `match_in_n` is high.
- R10: `match_out_n` is low when `match_in_n` is low or the slice's status shows a match. `full_out_n` is low only when `full_in_n` is low and every local entry is valid.
- R11: A move to next free writes the comparand into the lowest-addressed invalid entry and sets its validity bit. It acts only in the slice with `full_in_n` low that is not itself full, and that same slice alone answers a next-free read with {page, free address}.
- R12: Opcode 6 clears one validity bit without running a compare.
- R13: Reset (synchronous, active-high) clears all validity bits, the comparand, the mask, the page and the status. It sets device select to FFFFh, the write target and read source to the comparand, the command-read word to the status address, and the address register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Slice enable for a bus cycle |
| is_cmd | input | 1 | 1 = command cycle, 0 = data cycle |
| is_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| dq | inout | 16 | Shared data/command bus |
| match_in_n | input | 1 | Chained match from the previous slice, active-low |
| full_in_n | input | 1 | Chained full from the previous slice, active-low |
| match_out_n | output | 1 | Chained match to the next slice, active-low |
| full_out_n | output | 1 | Chained full to the next slice, active-low |
| match_n | output | 1 | Local match flag, active-low |
| multi_n | output | 1 | Local multiple-match flag, active-low |

## Verification
Two slices on paged addresses 0 and 1 share the bus. Compare keys are chosen so that only the first slice matches, only the second matches, both match, or nothing matches. These cases separate local priority from chain priority, and they show whether a slice that has no match, or that is shadowed by an earlier slice, stays off the bus. Mask patterns of none, one byte and all bits separate exact matching from don't-care matching. A cleared entry followed by a forced compare shows that invalid entries are skipped and that validity changes alone leave the status alone. Filling the first slice and then the second with next-free moves walks the free pointer across the slice boundary and sets each chained full flag in turn.

// File: rtl/cam_pkg.sv
package cam_pkg;

    localparam int CAM_DW    = 16;
    localparam int CAM_DEPTH = 16;
    localparam int OPC_W     = 4;

    typedef enum logic [3:0] {
        OP_NOP       = 4'h0,
        OP_SEL_DST   = 4'h1,
        OP_SEL_SRC   = 4'h2,
        OP_CMP       = 4'h3,
        OP_MOVE_NF   = 4'h4,
        OP_SET_ADDR  = 4'h5,
        OP_CLR_VALID = 4'h6,
        OP_SEL_RD    = 4'h7,
        OP_OVR_DSEL  = 4'h8,
        OP_OVR_PAGE  = 4'h9
    } opcode_e;

    typedef enum logic [1:0] {
        PATH_CMP = 2'd0,
        PATH_MSK = 2'd1,
        PATH_MEM = 2'd2
    } path_e;

    typedef enum logic [1:0] {
        RSEL_STAT = 2'd0,
        RSEL_FLAG = 2'd1,
        RSEL_FREE = 2'd2
    } rsel_e;

    typedef enum logic [1:0] {
        OVR_NONE = 2'd0,
        OVR_DSEL = 2'd1,
        OVR_PAGE = 2'd2
    } ovr_e;

    // packed MSB first: full is bit 2, multi bit 1, hit bit 0
    typedef struct packed {
        logic full;
        logic multi;
        logic hit;
    } flags_t;

    function automatic path_e dec_path(input logic [1:0] code);
        case (code)
            2'd1:    return PATH_MSK;
            2'd2:    return PATH_MEM;
            default: return PATH_CMP;
        endcase
    endfunction

    function automatic rsel_e dec_rsel(input logic [1:0] code);
        case (code)
            2'd1:    return RSEL_FLAG;
            2'd2:    return RSEL_FREE;
            default: return RSEL_STAT;
        endcase
    endfunction

endpackage

// File: rtl/cam_prio.sv
module cam_prio #(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [AW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = AW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/cam_store.sv
module cam_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             clr_en,
    input  logic [AW-1:0]    clr_idx,
    input  logic [DW-1:0]    key,
    input  logic [DW-1:0]    mask,
    input  logic [AW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic [DEPTH-1:0] valid,
    output logic [DEPTH-1:0] hits
);
    logic [DW-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic          v_q;
        logic [DW-1:0] w_q;

        always_ff @(posedge clk) begin
            if (rst)                                v_q <= 1'b0;
            else if (wr_en && wr_idx == AW'(i))     v_q <= 1'b1;
            else if (clr_en && clr_idx == AW'(i))   v_q <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == AW'(i)) w_q <= wr_data;
        end

        assign valid[i] = v_q;
        assign words[i] = w_q;
        assign hits[i]  = v_q && (((w_q ^ key) & ~mask) == '0);
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/cam_slice.sv
module cam_slice
    import cam_pkg::*;
#(
    parameter int DW    = CAM_DW,
    parameter int DEPTH = CAM_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          is_cmd,
    input  logic          is_wr,
    inout  wire  [DW-1:0] dq,
    input  logic          match_in_n,
    input  logic          full_in_n,
    output logic          match_out_n,
    output logic          full_out_n,
    output logic          match_n,
    output logic          multi_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = DW - AW;

    // architectural state
    logic [DW-1:0] comp_q, mask_q, dsel_q;
    logic [PW-1:0] page_q;
    logic [AW-1:0] addr_q, st_addr_q;
    path_e         dst_q, src_q;
    rsel_e         rsel_q;
    ovr_e          ovr_q;
    flags_t        st_q;

    // decode
    opcode_e op;
    logic    sel, cmd_wr, dat_wr, cmd_ok, plain_wr;
    logic    comp_wr, mask_wr, mem_wr, mv_acc, cmp_go, clr_go;

    assign op       = opcode_e'(dq[DW-1 -: OPC_W]);
    assign sel      = (dsel_q == {DW{1'b1}}) || (dsel_q == DW'(page_q));
    assign cmd_wr   = en && is_wr && is_cmd;
    assign dat_wr   = en && is_wr && !is_cmd;
    assign cmd_ok   = cmd_wr && sel;
    assign plain_wr = dat_wr && sel && (ovr_q == OVR_NONE);
    assign comp_wr  = plain_wr && (dst_q == PATH_CMP);
    assign mask_wr  = plain_wr && (dst_q == PATH_MSK);
    assign mem_wr   = plain_wr && (dst_q == PATH_MEM);
    assign clr_go   = cmd_ok && (op == OP_CLR_VALID);

    // array and priority logic
    logic [DW-1:0]    key_nx, msk_nx, rd_word, st_wdata;
    logic [DEPTH-1:0] valid, hits;
    logic [AW-1:0]    hit_idx, nf_idx, st_widx;
    logic             any_hit, has_free, local_full, nf_pos, st_wen;

    assign key_nx = comp_wr ? dq : comp_q;
    assign msk_nx = mask_wr ? dq : mask_q;

    assign local_full = !has_free;
    assign nf_pos     = !full_in_n && !local_full;
    assign mv_acc     = cmd_ok && (op == OP_MOVE_NF) && nf_pos;
    assign cmp_go     = comp_wr || mask_wr || (cmd_ok && op == OP_CMP);

    assign st_wen   = mem_wr || mv_acc;
    assign st_widx  = mv_acc ? nf_idx : addr_q;
    assign st_wdata = mv_acc ? comp_q : dq;

    cam_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (st_wen),
        .wr_idx  (st_widx),
        .wr_data (st_wdata),
        .clr_en  (clr_go),
        .clr_idx (dq[AW-1:0]),
        .key     (key_nx),
        .mask    (msk_nx),
        .rd_idx  (addr_q),
        .rd_data (rd_word),
        .valid   (valid),
        .hits    (hits)
    );

    cam_prio #(.N(DEPTH), .AW(AW)) match_enc_i (
        .req (hits),
        .any (any_hit),
        .idx (hit_idx)
    );

    cam_prio #(.N(DEPTH), .AW(AW)) free_enc_i (
        .req (~valid),
        .any (has_free),
        .idx (nf_idx)
    );

    // registers
    always_ff @(posedge clk) begin
        if (rst) begin
            comp_q    <= '0;
            mask_q    <= '0;
            dsel_q    <= '1;
            page_q    <= '0;
            addr_q    <= '0;
            dst_q     <= PATH_CMP;
            src_q     <= PATH_CMP;
            rsel_q    <= RSEL_STAT;
            ovr_q     <= OVR_NONE;
            st_q      <= '0;
            st_addr_q <= '0;
        end else begin
            if (cmd_ok) begin
                case (op)
                    OP_SEL_DST:  dst_q  <= dec_path(dq[1:0]);
                    OP_SEL_SRC:  src_q  <= dec_path(dq[1:0]);
                    OP_SET_ADDR: addr_q <= dq[AW-1:0];
                    OP_SEL_RD:   rsel_q <= dec_rsel(dq[1:0]);
                    OP_OVR_PAGE: ovr_q  <= OVR_PAGE;
                    default: ;
                endcase
            end
            if (cmd_wr && op == OP_OVR_DSEL) ovr_q <= OVR_DSEL;
            if (dat_wr && ovr_q == OVR_DSEL) begin
                dsel_q <= dq;
                ovr_q  <= OVR_NONE;
            end else if (dat_wr && sel && ovr_q == OVR_PAGE) begin
                page_q <= dq[PW-1:0];
                ovr_q  <= OVR_NONE;
            end
            if (comp_wr) comp_q <= dq;
            if (mask_wr) mask_q <= dq;
            if (cmp_go) begin
                st_q.hit   <= any_hit;
                st_q.multi <= ($countones(hits) > 1);
                st_q.full  <= local_full;
                st_addr_q  <= hit_idx;
            end
        end
    end

    // read path
    logic          drive;
    logic [DW-1:0] out_word;

    always_comb begin
        drive    = 1'b0;
        out_word = '0;
        if (en && !is_wr && sel) begin
            if (!is_cmd) begin
                drive = st_q.hit;
                case (src_q)
                    PATH_MSK: out_word = mask_q;
                    PATH_MEM: out_word = rd_word;
                    default:  out_word = comp_q;
                endcase
            end else begin
                case (rsel_q)
                    RSEL_FREE: begin
                        drive    = nf_pos;
                        out_word = {page_q, nf_idx};
                    end
                    RSEL_FLAG: begin
                        drive    = st_q.hit && match_in_n;
                        out_word = DW'(st_q);
                    end
                    default: begin
                        drive    = st_q.hit && match_in_n;
                        out_word = {page_q, st_addr_q};
                    end
                endcase
            end
        end
    end

    assign dq = drive ? out_word : {DW{1'bz}};

    // flags
    assign match_n     = !st_q.hit;
    assign multi_n     = !st_q.multi;
    assign match_out_n = match_in_n && !st_q.hit;
    assign full_out_n  = full_in_n || !local_full;

endmodule

// File: rtl/cam_slice_chk.sv
module cam_slice_chk #(
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             is_cmd,
    input logic             is_wr,
    input logic             full_in_n,
    input logic             full_out_n,
    input logic             match_n,
    input logic             multi_n,
    input logic             drive,
    input logic             sel,
    input logic             mv_acc,
    input logic [DEPTH-1:0] valid
);
    assert_multi_needs_hit_R4: assert property (@(posedge clk) disable iff (rst)
        !multi_n |-> !match_n);

    assert_drive_only_on_read_R1: assert property (@(posedge clk) disable iff (rst)
        drive |-> (en && !is_wr));

    assert_blocked_without_match_R8: assert property (@(posedge clk) disable iff (rst)
        (drive && !is_cmd) |-> !match_n);

    assert_unselected_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        drive |-> sel);

    assert_full_chain_R10: assert property (@(posedge clk) disable iff (rst)
        !full_out_n |-> !full_in_n);

    assert_move_fills_one_R11: assert property (@(posedge clk) disable iff (rst)
        mv_acc |=> ($countones(valid) == $past($countones(valid)) + 1));
endmodule

bind cam_slice cam_slice_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .is_cmd     (is_cmd),
    .is_wr      (is_wr),
    .full_in_n  (full_in_n),
    .full_out_n (full_out_n),
    .match_n    (match_n),
    .multi_n    (multi_n),
    .drive      (drive),
    .sel        (sel),
    .mv_acc     (mv_acc),
    .valid      (valid)
);

// File: tb/cam_slice_tb_top.sv
module cam_slice_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en0 = 1'b0, en1 = 1'b0;
    logic        is_cmd = 1'b0, is_wr = 1'b0;
    logic        tb_oe = 1'b0;
    logic [15:0] tb_dq = 16'h0;
    wire  [15:0] dq;

    logic mo0, fo0, m0, mm0;
    logic mo1, fo1, m1, mm1;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign dq = tb_oe ? tb_dq : 16'hzzzz;

    cam_slice dut_i (
        .clk(clk), .rst(rst), .en(en0), .is_cmd(is_cmd), .is_wr(is_wr), .dq(dq),
        .match_in_n(1'b1), .full_in_n(1'b0),
        .match_out_n(mo0), .full_out_n(fo0), .match_n(m0), .multi_n(mm0)
    );

    cam_slice dut_b (
        .clk(clk), .rst(rst), .en(en1), .is_cmd(is_cmd), .is_wr(is_wr), .dq(dq),
        .match_in_n(mo0), .full_in_n(fo0),
        .match_out_n(mo1), .full_out_n(fo1), .match_n(m1), .multi_n(mm1)
    );

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_idle(input string req, input string what, input logic [15:0] got);
        n_run++;
        if (!($isunknown(got) || got == 16'h0)) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected zzzz", req, what, got);
        end
    endtask

    task automatic wr(input logic e0, input logic e1, input logic c, input logic [15:0] d);
        @(negedge clk);
        en0 = e0; en1 = e1; is_cmd = c; is_wr = 1'b1; tb_oe = 1'b1; tb_dq = d;
        @(posedge clk);
        #1;
    endtask

    task automatic cmd(input logic e0, input logic e1, input logic [3:0] op, input logic [11:0] arg);
        wr(e0, e1, 1'b1, {op, arg});
    endtask

    task automatic dat(input logic e0, input logic e1, input logic [15:0] d);
        wr(e0, e1, 1'b0, d);
    endtask

    task automatic rd(input logic e0, input logic e1, input logic c, output logic [15:0] v);
        @(negedge clk);
        en0 = e0; en1 = e1; is_cmd = c; is_wr = 1'b0; tb_oe = 1'b0;
        #2 v = dq;
    endtask

    task automatic settle();
        @(negedge clk);
        en0 = 1'b0; en1 = 1'b0; is_wr = 1'b0; tb_oe = 1'b0;
        #2;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [15:0] v;
        settle();
        check("R13", "slice0 match_n after reset", {15'h0, m0}, 16'h1);
        check("R13", "slice0 multi_n after reset", {15'h0, mm0}, 16'h1);
        check("R13", "slice1 match_out_n after reset", {15'h0, mo1}, 16'h1);
        check("R13", "slice0 full_out_n after reset", {15'h0, fo0}, 16'h1);
        rd(1, 1, 1'b1, v);
        check_idle("R13", "status read after reset", v);
    endtask

    task automatic t_init();
        logic [15:0] v;
        cmd(0, 1, 4'h9, 12'h0);          // page override, slice1 only
        dat(0, 1, 16'h0001);
        cmd(1, 1, 4'h1, 12'h2);          // write target = memory
        cmd(1, 0, 4'h5, 12'h0); dat(1, 0, 16'h0F0F);
        cmd(1, 0, 4'h5, 12'h2); dat(1, 0, 16'h1234);
        cmd(1, 0, 4'h5, 12'h5); dat(1, 0, 16'hABCD);
        cmd(1, 0, 4'h5, 12'h9); dat(1, 0, 16'h1234);
        cmd(0, 1, 4'h5, 12'h0); dat(0, 1, 16'h5555);
        cmd(0, 1, 4'h5, 12'h3); dat(0, 1, 16'h1234);
        cmd(1, 1, 4'h7, 12'h2);          // command read = next free
        rd(1, 1, 1'b1, v);
        check("R11", "next-free read after load", v, 16'h0001);
    endtask

    task automatic t_compare();
        logic [15:0] v;
        cmd(1, 1, 4'h1, 12'h0);          // write target = comparand
        dat(1, 1, 16'h1234);
        settle();
        check("R4", "slice0 match_n two hits", {15'h0, m0}, 16'h0);
        check("R4", "slice0 multi_n two hits", {15'h0, mm0}, 16'h0);
        check("R4", "slice1 multi_n one hit", {15'h0, mm1}, 16'h1);
        check("R10", "slice1 match_out_n", {15'h0, mo1}, 16'h0);
        cmd(1, 1, 4'h7, 12'h0);
        rd(1, 1, 1'b1, v);
        check("R2", "status addr after comparand write", v, 16'h0002);
        cmd(1, 1, 4'h7, 12'h1);
        rd(1, 1, 1'b1, v);
        check("R5", "status flags word", v, 16'h0003);
        cmd(1, 1, 4'h7, 12'h0);
        rd(0, 1, 1'b1, v);
        check_idle("R9", "shadowed slice status read", v);
        dat(1, 1, 16'h5555);
        settle();
        check("R3", "slice0 match_n no equal entry", {15'h0, m0}, 16'h1);
        rd(1, 1, 1'b1, v);
        check("R5", "status addr carries page", v, 16'h0010);
        rd(1, 1, 1'b0, v);
        check("R8", "data read from matching slice", v, 16'h5555);
        rd(1, 0, 1'b0, v);
        check_idle("R8", "data read from slice without match", v);
        cmd(1, 0, 4'h7, 12'h2);
        rd(1, 0, 1'b1, v);
        check("R8", "next-free read without match", v, 16'h0001);
        cmd(1, 1, 4'h7, 12'h0);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        dat(1, 1, 16'hAB00);
        settle();
        check("R3", "unmasked compare misses", {15'h0, m0}, 16'h1);
        cmd(1, 1, 4'h1, 12'h1);          // write target = mask
        dat(1, 1, 16'h00FF);
        rd(1, 1, 1'b1, v);
        check("R2", "mask write runs compare", v, 16'h0005);
        check("R3", "low byte don't-care single hit", {15'h0, mm0}, 16'h1);
        dat(1, 1, 16'hFFFF);             // target persists as mask
        settle();
        check("R1", "target persists: full mask multi", {15'h0, mm0}, 16'h0);
        cmd(1, 1, 4'h7, 12'h1);
        rd(1, 1, 1'b1, v);
        check("R4", "lowest of all valid", v, 16'h0003);
        rd(1, 0, 1'b0, v);
        check("R1", "comparand kept by mask writes", v, 16'hAB00);
        dat(1, 1, 16'h0000);
        cmd(1, 1, 4'h7, 12'h0);
    endtask

    task automatic t_valid();
        logic [15:0] v;
        cmd(1, 1, 4'h1, 12'h0);
        dat(1, 1, 16'h1234);
        rd(1, 1, 1'b1, v);
        check("R4", "status before clear", v, 16'h0002);
        cmd(1, 0, 4'h6, 12'h2);          // clear validity of entry 2
        settle();
        check("R12", "clear leaves multi flag", {15'h0, mm0}, 16'h0);
        rd(1, 1, 1'b1, v);
        check("R12", "clear leaves status addr", v, 16'h0002);
        cmd(1, 0, 4'h3, 12'h0);          // forced compare
        settle();
        check("R3", "invalid entry skipped multi_n", {15'h0, mm0}, 16'h1);
        rd(1, 1, 1'b1, v);
        check("R2", "forced compare status", v, 16'h0009);
    endtask

    task automatic t_devsel();
        logic [15:0] v;
        cmd(1, 1, 4'h8, 12'h0);
        dat(1, 1, 16'h0001);             // target page 1 only
        dat(1, 1, 16'h5555);
        rd(1, 1, 1'b0, v);
        check("R7", "only selected slice drives", v, 16'h5555);
        settle();
        check("R6", "selected slice compared", {15'h0, m1}, 16'h0);
        cmd(1, 1, 4'h8, 12'h0);
        dat(1, 1, 16'hFFFF);             // broadcast again
        rd(1, 0, 1'b0, v);
        check("R7", "unselected slice kept comparand", v, 16'h1234);
        cmd(1, 1, 4'h8, 12'h0);
        dat(1, 1, 16'h0000);             // target page 0 only
        rd(1, 0, 1'b0, v);
        check("R6", "page-equal select reads", v, 16'h1234);
        cmd(1, 1, 4'h8, 12'h0);
        dat(1, 1, 16'hFFFF);
    endtask

    task automatic t_free();
        logic [15:0] v;
        cmd(1, 1, 4'h1, 12'h0);
        dat(1, 1, 16'h7777);
        cmd(1, 1, 4'h7, 12'h2);
        rd(1, 1, 1'b1, v);
        check("R11", "first free entry", v, 16'h0001);
        cmd(1, 1, 4'h4, 12'h0);
        rd(1, 1, 1'b1, v);
        check("R11", "free pointer advanced", v, 16'h0002);
        for (int k = 0; k < 12; k++) cmd(1, 1, 4'h4, 12'h0);
        settle();
        check("R10", "slice0 full_out_n when full", {15'h0, fo0}, 16'h0);
        check("R10", "slice1 full_out_n not full", {15'h0, fo1}, 16'h1);
        rd(1, 1, 1'b1, v);
        check("R11", "free pointer crosses slice", v, 16'h0011);
        cmd(1, 1, 4'h4, 12'h0);
        rd(1, 1, 1'b1, v);
        check("R11", "move landed in slice1", v, 16'h0012);
        cmd(1, 1, 4'h3, 12'h0);
        cmd(1, 1, 4'h7, 12'h0);
        rd(1, 1, 1'b1, v);
        check("R11", "moved comparand found", v, 16'h0001);
        cmd(1, 1, 4'h7, 12'h1);
        rd(1, 1, 1'b1, v);
        check("R5", "flags with full set", v, 16'h0007);
        for (int k = 0; k < 13; k++) cmd(1, 1, 4'h4, 12'h0);
        settle();
        check("R10", "system full_out_n", {15'h0, fo1}, 16'h0);
        cmd(1, 1, 4'h7, 12'h2);
        rd(1, 1, 1'b1, v);
        check_idle("R11", "no free slice answers", v);
    endtask

    // ---------------- main ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_init();
        t_compare();
        t_mask();
        t_valid();
        t_devsel();
        t_free();
        settle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule